// File: doc/BRIEF.md
# Serial Frame Transmitter with Bit FIFO

This block sends a command frame, one bit per pulse of a 1x bit-rate enable, out on a single data line. Its data comes from a 32-bit FIFO that the host fills one byte at a time. Inside each byte the bits leave least significant first. Bytes leave in the order they were pushed. The frame length is given in bits. A typical short command is 10 or 30 bits.

There are two ways to run it. In fixed-length mode the host loads the whole frame, sets a non-zero length and strobes go; the block then shifts out exactly that many bits and pulses done. A length of zero selects open-ended mode, which is meant for frames longer than the FIFO. Here the host pushes bytes while the line drains the FIFO, watching the fill level, and asks to stop when the last byte is in. The frame ends cleanly once the FIFO is empty after a stop request.

The byte input is a valid/ready stream. `in_ready` is high while at least 8 bits of space are free. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. A byte offered while `in_ready` is low is dropped and counts as an overrun, because the host is expected to check the fill level first. Underrun and overrun flags stay set until the next accepted go.

Top module: `frame_tx`

## Requirements
- R1: After reset the line is high, the fill level is 0, `in_ready` is high, and busy, done, underrun and overrun are all low. While busy is low the line is high.
- R2: Each accepted byte adds 8 to `fill_bits`, which counts stored bits from 0 to 32. Bits are sent least significant bit first, in the order the bytes were pushed. A `bit_en` pulse while idle changes neither the line nor the fill level.
- R3: `in_ready` is high exactly when `fill_bits` is 24 or less. A byte offered with `in_ready` low is dropped and sets `overrun`.
- R4: A go while idle starts a frame and captures `frame_len`. A go while busy has no effect on the running frame.
- R5: With a non-zero length N, the first N `bit_en` pulses each put the next FIFO bit on the line, visible after that clock edge. Pulse N+1 returns the line high, drops busy and pulses done high for one cycle.
- R6: With length 0, bits are sent on every `bit_en` while the FIFO holds data. Once a `stop_req` pulse has been seen, a `bit_en` that finds the FIFO empty ends the frame: line high, busy low, done pulsed.
- R7: A byte accepted in the same cycle as a bit leaves the FIFO raises the fill level by 7, and the bit order is kept.
- R8: A `bit_en` that finds the FIFO empty while bits are still owed sets `underrun` and ends the frame without a done pulse. Bits are owed when a fixed-length frame has bits left, or when an open-ended frame has seen no stop request.
- R9: Underrun and overrun stay set until a go is accepted, which clears them. An error event in that same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to append to the FIFO |
| in_ready | output | 1 | At least 8 bits of FIFO space are free |
| frame_len | input | LEN_W (8) | Frame length in bits, 0 selects open-ended mode |
| go | input | 1 | Start strobe |
| stop_req | input | 1 | Ends open-ended mode once the FIFO drains |
| bit_en | input | 1 | 1x bit-rate enable, one clock wide |
| tx_line | output | 1 | Serial data out, idles high |
| fill_bits | output | 6 | Bits held in the FIFO |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when a frame ends cleanly |
| underrun | output | 1 | Sticky: FIFO ran dry while bits were owed |
| overrun | output | 1 | Sticky: byte offered with no space |

## Verification
Two things can happen in the same cycle: a byte push and a bit pop, when the host tops up the FIFO on the very edge where `bit_en` drains it. The bench provokes this in open-ended mode. It drains four bytes down to a fill of 24, then presents a fifth byte together with `bit_en`. It expects a fill of 31, and the new byte's bits must follow the earlier ones on the line with none lost or reordered. A second overlap is an overrun offered alongside go, which would clear the flags. The requirement says the overrun must survive that cycle.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic {ST_IDLE, ST_SHIFT} tx_state_e;

  typedef struct packed {
    logic underrun;
    logic overrun;
  } tx_err_t;
endpackage

// File: rtl/frame_tx_fifo.sv
module frame_tx_fifo #(
  parameter int FIFO_BITS = 32,
  parameter int BYTE_W    = 8,
  localparam int CNT_W    = $clog2(FIFO_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [BYTE_W-1:0] push_data,
  output logic              push_ready,
  input  logic              pop,
  output logic              head_bit,
  output logic              empty,
  output logic [CNT_W-1:0]  fill,
  output logic              overrun_evt
);
  localparam int SPACE_LIM = FIFO_BITS - BYTE_W;

  logic [FIFO_BITS-1:0] store_q, store_d, shifted, inserted;
  logic [CNT_W-1:0]     fill_q, fill_d, base;
  logic                 accept, pop_ok;

  assign push_ready  = (fill_q <= CNT_W'(SPACE_LIM));
  assign accept      = push_valid && push_ready;
  assign overrun_evt = push_valid && !push_ready;
  assign empty       = (fill_q == '0);
  assign pop_ok      = pop && !empty;
  assign head_bit    = store_q[0];
  assign fill        = fill_q;

  always_comb begin
    shifted  = pop_ok ? (store_q >> 1) : store_q;
    base     = pop_ok ? (fill_q - CNT_W'(1)) : fill_q;
    inserted = '0;
    if (accept)
      inserted = {{(FIFO_BITS-BYTE_W){1'b0}}, push_data} << base;
    store_d = shifted | inserted;
    fill_d  = base + (accept ? CNT_W'(BYTE_W) : CNT_W'(0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
      fill_q  <= '0;
    end else begin
      store_q <= store_d;
      fill_q  <= fill_d;
    end
  end
endmodule

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             stop_req,
  input  logic             bit_en,
  input  logic             fifo_empty,
  input  logic             head_bit,
  output logic             pop,
  output logic             go_take,
  output logic             underrun_evt,
  output logic             tx_line,
  output logic             busy,
  output logic             done
);
  tx_state_e        state_q;
  logic             open_q, stop_q, line_q, done_q;
  logic [LEN_W-1:0] left_q;
  logic             stop_eff, owed, finish_ok;

  assign go_take   = go && (state_q == ST_IDLE);
  assign stop_eff  = stop_q || stop_req;
  assign owed      = open_q ? !stop_eff : (left_q != '0);
  assign pop       = (state_q == ST_SHIFT) && bit_en && !fifo_empty &&
                     (open_q || left_q != '0);
  assign underrun_evt = (state_q == ST_SHIFT) && bit_en && fifo_empty && owed;
  assign finish_ok = (state_q == ST_SHIFT) && bit_en && !pop && !owed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      open_q  <= 1'b0;
      stop_q  <= 1'b0;
      left_q  <= '0;
      line_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          line_q <= 1'b1;
          if (go_take) begin
            state_q <= ST_SHIFT;
            open_q  <= (frame_len == '0);
            left_q  <= frame_len;
            stop_q  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (stop_req && open_q) stop_q <= 1'b1;
          if (pop) begin
            line_q <= head_bit;
            if (!open_q) left_q <= left_q - LEN_W'(1);
          end else if (underrun_evt || finish_ok) begin
            line_q  <= 1'b1;
            state_q <= ST_IDLE;
            done_q  <= finish_ok;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_line = line_q;
  assign busy    = (state_q == ST_SHIFT);
  assign done    = done_q;
endmodule

// File: rtl/frame_tx_flags.sv
module frame_tx_flags
  import frame_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clear,
  input  tx_err_t set_evt,
  output tx_err_t flags
);
  tx_err_t flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else flags_q <= (clear ? '0 : flags_q) | set_evt;
  end

  assign flags = flags_q;
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int FIFO_BITS = 32,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = 8,
  localparam int CNT_W    = $clog2(FIFO_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              go,
  input  logic              stop_req,
  input  logic              bit_en,
  output logic              tx_line,
  output logic [CNT_W-1:0]  fill_bits,
  output logic              busy,
  output logic              done,
  output logic              underrun,
  output logic              overrun
);
  logic    pop, head_bit, fifo_empty, go_take, under_evt, over_evt;
  tx_err_t err_evt, err_q;

  frame_tx_fifo #(.FIFO_BITS(FIFO_BITS), .BYTE_W(BYTE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(in_valid), .push_data(in_data), .push_ready(in_ready),
    .pop(pop), .head_bit(head_bit), .empty(fifo_empty),
    .fill(fill_bits), .overrun_evt(over_evt)
  );

  frame_tx_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .frame_len(frame_len),
    .stop_req(stop_req), .bit_en(bit_en), .fifo_empty(fifo_empty),
    .head_bit(head_bit), .pop(pop), .go_take(go_take),
    .underrun_evt(under_evt), .tx_line(tx_line), .busy(busy), .done(done)
  );

  assign err_evt = '{underrun: under_evt, overrun: over_evt};

  frame_tx_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clear(go_take),
    .set_evt(err_evt), .flags(err_q)
  );

  assign underrun = err_q.underrun;
  assign overrun  = err_q.overrun;
endmodule

// File: rtl/frame_tx_chk.sv
module frame_tx_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             bit_en,
  input logic             tx_line,
  input logic [CNT_W-1:0] fill_bits,
  input logic             busy,
  input logic             done,
  input logic             underrun,
  input logic             overrun
);
  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  // R2
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && in_ready) && !bit_en) |=> $stable(fill_bits));

  // R2
  fill_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !bit_en) |=> (fill_bits == $past(fill_bits) + CNT_W'(8)));

  // R3
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tx_line));

  // R8
  underrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (!busy && !done));
endmodule

bind frame_tx frame_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .bit_en(bit_en), .tx_line(tx_line), .fill_bits(fill_bits), .busy(busy),
  .done(done), .underrun(underrun), .overrun(overrun)
);

// File: tb/sim_frame_tx.sv
module sim_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, go, stop_req, bit_en;
  logic [7:0] in_data, frame_len;
  logic       in_ready, tx_line, busy, done, underrun, overrun;
  logic [5:0] fill_bits;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .frame_len(frame_len), .go(go), .stop_req(stop_req),
    .bit_en(bit_en), .tx_line(tx_line), .fill_bits(fill_bits), .busy(busy),
    .done(done), .underrun(underrun), .overrun(overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: apply inputs at negedge, sample at the following negedge.
  task automatic step(input logic be, input logic pv, input logic [7:0] pd,
                      input logic g, input logic sr);
    @(negedge clk);
    bit_en = be; in_valid = pv; in_data = pd; go = g; stop_req = sr;
    @(posedge clk);
    @(negedge clk);
    bit_en = 0; in_valid = 0; go = 0; stop_req = 0;
  endtask

  task automatic push(input logic [7:0] b);  step(0, 1, b, 0, 0); endtask
  task automatic tick();                    step(1, 0, 8'h00, 0, 0); endtask
  task automatic start(input logic [7:0] n);
    frame_len = n;
    step(0, 0, 8'h00, 1, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; in_data = 0; go = 0; stop_req = 0; bit_en = 0;
    frame_len = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  function automatic logic frame_bit(input logic [7:0] bytes [8], input int i);
    return bytes[i/8][i%8];
  endfunction

  task automatic t_reset();
    do_reset();
    check("R1 line", tx_line, 1);
    check("R1 fill", fill_bits, 0);
    check("R1 ready", in_ready, 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 flags", {underrun, overrun}, 0);
  endtask

  task automatic t_idle_tick();
    do_reset();
    push(8'h00);
    check("R2 fill after push", fill_bits, 8);
    tick();
    check("R2 idle tick line", tx_line, 1);
    check("R2 idle tick fill", fill_bits, 8);
  endtask

  task automatic t_oneshot10();
    logic [7:0] b [8];
    b = '{8'hA5, 8'h03, 0, 0, 0, 0, 0, 0};
    do_reset();
    push(b[0]); push(b[1]);
    check("R2 fill two bytes", fill_bits, 16);
    start(8'd10);
    check("R4 busy after go", busy, 1);
    for (int i = 0; i < 10; i++) begin
      tick();
      check($sformatf("R5 bit %0d", i), tx_line, frame_bit(b, i));
      if (i == 3) begin
        frame_len = 0;
        step(0, 0, 8'h00, 1, 0);
        check("R4 go while busy", busy, 1);
      end
    end
    check("R5 no early done", done, 0);
    check("R2 fill mid", fill_bits, 6);
    tick();
    check("R5 done pulse", done, 1);
    check("R5 line high", tx_line, 1);
    check("R5 busy low", busy, 0);
    step(0, 0, 8'h00, 0, 0);
    check("R5 done one cycle", done, 0);
  endtask

  task automatic t_oneshot30_overrun();
    logic [7:0] b [8];
    b = '{8'h3C, 8'hC3, 8'h5A, 8'h96, 0, 0, 0, 0};
    do_reset();
    for (int i = 0; i < 4; i++) push(b[i]);
    check("R3 fill full", fill_bits, 32);
    check("R3 ready low", in_ready, 0);
    push(8'hFF);
    check("R3 overrun set", overrun, 1);
    check("R3 byte dropped", fill_bits, 32);
    frame_len = 8'd30;
    step(0, 1, 8'hFF, 1, 0);
    check("R9 overrun wins in go cycle", overrun, 1);
    for (int i = 0; i < 30; i++) begin
      tick();
      check($sformatf("R5 bit %0d of 30", i), tx_line, frame_bit(b, i));
    end
    tick();
    check("R5 done after 30", done, 1);
    check("R5 leftover bits", fill_bits, 2);
    check("R9 overrun sticky", overrun, 1);
    push(8'h00);
    start(8'd1);
    check("R9 cleared by go", overrun, 0);
  endtask

  task automatic t_continuous40();
    logic [7:0] b [8];
    b = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h9A, 0, 0, 0};
    do_reset();
    for (int i = 0; i < 4; i++) push(b[i]);
    start(8'd0);
    for (int i = 0; i < 8; i++) begin
      tick();
      check($sformatf("R6 bit %0d", i), tx_line, frame_bit(b, i));
    end
    check("R3 ready at 24", in_ready, 1);
    step(1, 1, b[4], 0, 0);
    check("R7 fill push+pop", fill_bits, 31);
    check("R7 bit 8", tx_line, frame_bit(b, 8));
    step(0, 0, 8'h00, 0, 1);
    for (int i = 9; i < 40; i++) begin
      tick();
      check($sformatf("R7 bit %0d", i), tx_line, frame_bit(b, i));
    end
    check("R6 still busy", busy, 1);
    tick();
    check("R6 done", done, 1);
    check("R6 no underrun", underrun, 0);
    check("R6 line high", tx_line, 1);
  endtask

  task automatic t_underruns();
    do_reset();
    push(8'hF0);
    start(8'd0);
    for (int i = 0; i < 8; i++) tick();
    check("R8 no underrun yet", underrun, 0);
    tick();
    check("R8 open underrun", underrun, 1);
    check("R8 no done", done, 0);
    check("R8 busy low", busy, 0);
    push(8'h01);
    start(8'd10);
    check("R9 underrun cleared", underrun, 0);
    for (int i = 0; i < 8; i++) tick();
    tick();
    check("R8 fixed underrun", underrun, 1);
    check("R8 fixed no done", done, 0);
    check("R8 line high", tx_line, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_tick();
    t_oneshot10();
    t_oneshot30_overrun();
    t_continuous40();
    t_underruns();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule